// File: doc/BRIEF.md
# Interlaced Vertical Sync Regenerator

This block rebuilds a correct interlaced vertical sync from signals that a progressive timing engine already drives. It watches the data-enable level together with two tick strobes: one marks the start of every line (horizontal sync onset) and one marks the middle of every line. From these it finds where the active picture of each field ends. It then counts front-porch half-lines and places the sync pulse on a line boundary or a mid-line boundary, as the field parity requires. It holds the pulse for a programmed number of half-lines and then counts the back porch.

Two per-field parameter sets sit side by side in one 32-bit configuration word, and the block uses them alternately. If data-enable is already active when a back porch ends, the alternation restarts at the first set, so the block falls back into step with the video after any disturbance. The package also provides a function that turns mode geometry (visible lines, sync start, sync end, total lines) into the configuration word and the sync length code. That function rounds the geometry and clamps the front porch. All inputs are taken to be synchronous to `clk`.

Top module: `ivs_regen`

## Requirements
- R1: While reset is asserted and after it, until the first pulse, `vsync_o` sits at its inactive level, which equals `cfg_vs_inv`. The field phase starts at the first parameter set.
- R2: The active level of data-enable is `de_in ^ cfg_de_inv`. After data-enable goes active, the block samples it at each mid-line tick that follows a line tick. The first such sample that finds it inactive starts the front porch, and that tick does not count toward the porch.
- R3: The front porch then waits for as many further half-line ticks as the current field's count in bits 6:0. A half-line tick is `hs_tick | mid_tick`. A count of zero waits for none, and a tick sampled in the cycle a count is loaded is never counted.
- R4: Bit 7 of the current field selects where the pulse starts. When it is clear, the pulse starts on the next line tick. When it is set, it starts on the next half-line tick of either kind. `vsync_o` changes in the cycle after that tick is sampled.
- R5: The pulse lasts `cfg_sync_len + 1` half-line ticks and ends in the cycle after the last of them.
- R6: After the pulse, the block waits for the back-porch count in bits 15:8 of the current field. Field set 0 occupies bits 15:0 of `cfg_timing` and field set 1 bits 31:16. If data-enable is inactive when the back porch ends, the next field uses the other set.
- R7: If data-enable is active when the back porch ends, the next field uses field set 0, whatever the set just used.
- R8: `vsync_o` equals the internal pulse XOR `cfg_vs_inv`. Inverting `de_in` together with `cfg_de_inv` leaves the timing unchanged.
- R9: `ivs_pkg::pack_timing` computes the front porch `vfp` and back porch `vbp` from the mode geometry. Set 0 gets count `vfp-2`, flag `vfp&1` and back porch `vbp`. Set 1 gets count `vfp-3`, flag `~vfp&1` and back porch `vbp+1`. `ivs_pkg::sync_code` returns `vsync_end - vsync_start - 1`.
- R10: The packing clamps `vfp` to 3..128. Any excess above 128 is added to `vbp`. A shortfall below 3 is taken from `vbp`, and `vbp` never goes below zero.
- R11: The packing takes `vfp` against the visible line count rounded down to even, and `vbp` from the total line count forced odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| de_in | input | 1 | Snooped data-enable level |
| hs_tick | input | 1 | One-cycle strobe at each line start |
| mid_tick | input | 1 | One-cycle strobe at each mid-line point |
| cfg_timing | input | 32 | Two packed per-field parameter sets |
| cfg_sync_len | input | SYNC_W | Pulse length in half-lines minus one |
| cfg_de_inv | input | 1 | Data-enable is active low when set |
| cfg_vs_inv | input | 1 | Output pulse is active low when set |
| vsync_o | output | 1 | Regenerated vertical sync |

## Verification
The bench aims at three corner cases. The first is the front porch whose field count is zero: a design that always waits one tick there starts the second field's pulse a half-line late. The second is the choice between line-aligned and mid-line-aligned starts for odd and even porch lengths: a wrong choice moves the pulse by one half-line in exactly one of the two fields. The third is phase resynchronisation, where the back porch ends inside the next field's active lines. A design that ignores data-enable there keeps alternating and places every second pulse on the wrong half-line. Clamp and rounding vectors at both porch limits are also checked. Here an off-by-one design shows up as a wrong word, or as a back porch that wraps instead of flooring at zero.

// File: rtl/ivs_pkg.sv
`timescale 1ns/1ps
package ivs_pkg;

    // Per-field layout: front-porch count, alignment flag, back-porch count
    localparam int FP_W       = 7;
    localparam int BP_W       = 8;
    localparam int FIELD_W    = FP_W + 1 + BP_W;
    localparam int NFIELD     = 2;
    localparam int WORD_W     = FIELD_W * NFIELD;
    localparam int SYNC_W_DEF = 8;
    localparam int MODE_W     = 16;
    localparam int VFP_MIN    = 3;
    localparam int VFP_MAX    = 128;

    typedef struct packed {
        logic [BP_W-1:0] bp;
        logic            align;
        logic [FP_W-1:0] fp;
    } field_t;

    typedef enum logic [2:0] {
        ST_WAIT_DE,
        ST_ACT_HS,
        ST_ACT_MID,
        ST_FP,
        ST_ALIGN,
        ST_VS,
        ST_BP,
        ST_CHECK
    } state_t;

    // Build the two-field configuration word from mode geometry
    function automatic logic [WORD_W-1:0] pack_timing(
        input logic [MODE_W-1:0] vdisp,
        input logic [MODE_W-1:0] vs_start,
        input logic [MODE_W-1:0] vs_end,
        input logic [MODE_W-1:0] vtotal
    );
        int     vfp;
        int     vbp;
        field_t f0;
        field_t f1;
        vfp = int'(vs_start) - int'(vdisp & ~MODE_W'(1));
        vbp = int'(vtotal | MODE_W'(1)) - int'(vs_end);
        if (vfp > VFP_MAX) begin
            vbp = vbp + (vfp - VFP_MAX);
            vfp = VFP_MAX;
        end else if (vfp < VFP_MIN) begin
            vbp = (vbp > (VFP_MIN - vfp)) ? (vbp - VFP_MIN + vfp) : 0;
            vfp = VFP_MIN;
        end
        f0.fp    = FP_W'(vfp - 2);
        f0.align = ((vfp & 1) != 0);
        f0.bp    = BP_W'(vbp);
        f1.fp    = FP_W'(vfp - 3);
        f1.align = ((vfp & 1) == 0);
        f1.bp    = BP_W'(vbp + 1);
        return {f1, f0};
    endfunction

    function automatic logic [SYNC_W_DEF-1:0] sync_code(
        input logic [MODE_W-1:0] vs_start,
        input logic [MODE_W-1:0] vs_end
    );
        return SYNC_W_DEF'(int'(vs_end) - int'(vs_start) - 1);
    endfunction

endpackage

// File: rtl/ivs_field_sel.sv
`timescale 1ns/1ps
module ivs_field_sel
    import ivs_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              phase,
    output field_t            cur_fld
);

    field_t fld [NFIELD];

    for (genvar g = 0; g < NFIELD; g++) begin : g_unpack
        assign fld[g] = field_t'(word[g*FIELD_W +: FIELD_W]);
    end

    assign cur_fld = fld[phase];

endmodule

// File: rtl/ivs_half_cnt.sv
`timescale 1ns/1ps
module ivs_half_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         last
);

    logic [W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (tick && (rem_q != '0)) begin
            rem_q <= rem_q - W'(1);
        end
    end

    assign last = (rem_q == W'(1));

endmodule

// File: rtl/ivs_seq.sv
`timescale 1ns/1ps
module ivs_seq
    import ivs_pkg::*;
#(
    parameter int SYNC_W = SYNC_W_DEF,
    parameter int CNT_W  = SYNC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de_act,
    input  logic              hs_tick,
    input  logic              mid_tick,
    input  field_t            cur_fld,
    input  logic [SYNC_W-1:0] sync_len,
    input  logic              cnt_last,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              phase,
    output logic              vs_active
);

    state_t st_q;
    state_t st_d;
    logic   phase_d;
    logic   half_tick;

    assign half_tick = hs_tick | mid_tick;

    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        phase_d  = phase;
        unique case (st_q)
            ST_WAIT_DE: begin
                if (de_act) st_d = ST_ACT_HS;
            end
            ST_ACT_HS: begin
                if (hs_tick) st_d = ST_ACT_MID;
            end
            ST_ACT_MID: begin
                if (mid_tick) begin
                    if (de_act) begin
                        st_d = ST_ACT_HS;
                    end else if (cur_fld.fp == '0) begin
                        st_d = ST_ALIGN;
                    end else begin
                        st_d     = ST_FP;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(cur_fld.fp);
                    end
                end
            end
            ST_FP: begin
                if (half_tick && cnt_last) st_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (cur_fld.align ? half_tick : hs_tick) begin
                    st_d     = ST_VS;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(sync_len) + CNT_W'(1);
                end
            end
            ST_VS: begin
                if (half_tick && cnt_last) begin
                    if (cur_fld.bp == '0) begin
                        st_d = ST_CHECK;
                    end else begin
                        st_d     = ST_BP;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(cur_fld.bp);
                    end
                end
            end
            ST_BP: begin
                if (half_tick && cnt_last) st_d = ST_CHECK;
            end
            ST_CHECK: begin
                st_d    = ST_WAIT_DE;
                phase_d = de_act ? 1'b0 : ~phase;
            end
            default: st_d = ST_WAIT_DE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_WAIT_DE;
            phase     <= 1'b0;
            vs_active <= 1'b0;
        end else begin
            st_q      <= st_d;
            phase     <= phase_d;
            vs_active <= (st_d == ST_VS);
        end
    end

endmodule

// File: rtl/ivs_regen.sv
`timescale 1ns/1ps
module ivs_regen
    import ivs_pkg::*;
#(
    parameter int SYNC_W = SYNC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de_in,
    input  logic              hs_tick,
    input  logic              mid_tick,
    input  logic [WORD_W-1:0] cfg_timing,
    input  logic [SYNC_W-1:0] cfg_sync_len,
    input  logic              cfg_de_inv,
    input  logic              cfg_vs_inv,
    output logic              vsync_o
);

    localparam int CNT_A = (SYNC_W + 1 > BP_W) ? SYNC_W + 1 : BP_W;
    localparam int CNT_W = (CNT_A > FP_W) ? CNT_A : FP_W;

    logic             de_act;
    logic             phase;
    logic             vs_active;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_last;
    logic             cur_align;
    field_t           cur_fld;

    assign de_act    = de_in ^ cfg_de_inv;
    assign cur_align = cur_fld.align;

    ivs_field_sel u_sel (
        .word    (cfg_timing),
        .phase   (phase),
        .cur_fld (cur_fld)
    );

    ivs_half_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (hs_tick | mid_tick),
        .last     (cnt_last)
    );

    ivs_seq #(.SYNC_W(SYNC_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .de_act    (de_act),
        .hs_tick   (hs_tick),
        .mid_tick  (mid_tick),
        .cur_fld   (cur_fld),
        .sync_len  (cfg_sync_len),
        .cnt_last  (cnt_last),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .phase     (phase),
        .vs_active (vs_active)
    );

    assign vsync_o = vs_active ^ cfg_vs_inv;

endmodule

// File: rtl/ivs_regen_chk.sv
`timescale 1ns/1ps
module ivs_regen_chk #(
    parameter int SYNC_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              hs_tick,
    input logic              mid_tick,
    input logic [SYNC_W-1:0] cfg_sync_len,
    input logic              cfg_vs_inv,
    input logic              vsync_o,
    input logic              cur_align
);

    logic            vs_act;
    logic            tick;
    logic [SYNC_W:0] vs_cnt;

    assign vs_act = vsync_o ^ cfg_vs_inv;
    assign tick   = hs_tick | mid_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_cnt <= '0;
        end else if (vs_act && tick) begin
            vs_cnt <= vs_cnt + 1'b1;
        end else if (!vs_act) begin
            vs_cnt <= '0;
        end
    end

    AST_VS_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(vs_act) |-> $past(tick)); // R4
    AST_LINE_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(vs_act) && !$past(cur_align)) |-> $past(hs_tick)); // R4
    AST_VS_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(vs_act) |-> $past(tick)); // R5
    AST_VS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(vs_act) |-> (vs_cnt == ({1'b0, cfg_sync_len} + 1'b1))); // R5
    AST_VS_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        vs_act |-> (vs_cnt <= {1'b0, cfg_sync_len})); // R5

endmodule

bind ivs_regen ivs_regen_chk #(.SYNC_W(SYNC_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .hs_tick      (hs_tick),
    .mid_tick     (mid_tick),
    .cfg_sync_len (cfg_sync_len),
    .cfg_vs_inv   (cfg_vs_inv),
    .vsync_o      (vsync_o),
    .cur_align    (cur_align)
);

// File: tb/ivs_regen_tb_top.sv
`timescale 1ns/1ps
module ivs_regen_tb_top;

    localparam int LINE = 20;
    localparam int HALF = 10;
    localparam int MAXF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        de_in = 1'b0;
    logic        hs_tick = 1'b0;
    logic        mid_tick = 1'b0;
    logic [31:0] cfg_timing = '0;
    logic [7:0]  cfg_sync_len = '0;
    logic        cfg_de_inv = 1'b0;
    logic        cfg_vs_inv = 1'b0;
    logic        vsync_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int l0 [0:MAXF];
    int exp_rise [0:MAXF-1];
    int exp_fall [0:MAXF-1];
    int got_rise [0:MAXF-1];
    int got_fall [0:MAXF-1];

    always #2.5 clk = ~clk;

    ivs_regen dut_i (
        .clk          (clk),
        .rst          (rst),
        .de_in        (de_in),
        .hs_tick      (hs_tick),
        .mid_tick     (mid_tick),
        .cfg_timing   (cfg_timing),
        .cfg_sync_len (cfg_sync_len),
        .cfg_de_inv   (cfg_de_inv),
        .cfg_vs_inv   (cfg_vs_inv),
        .vsync_o      (vsync_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit tb_active(input int ln, input int nf, input int a);
        for (int f = 0; f < nf; f++)
            if (ln >= l0[f] && ln < l0[f] + a) return 1'b1;
        return 1'b0;
    endfunction

    // Run nf fields of a lines active each, alternating blank lengths
    task automatic run_fields(input logic [31:0] word, input int sync,
                              input bit dei, input bit vsi, input int a_lines,
                              input int b_even, input int b_odd, input int nf,
                              input string tag, input string req_start);
        int  ph;
        int  tot_lines;
        int  tick_idx;
        int  last_tick;
        int  nr;
        int  nfl;
        bit  prev;
        bit  vs;
        l0[0] = 2;
        for (int f = 0; f < nf; f++)
            l0[f+1] = l0[f] + a_lines + (((f % 2) == 1) ? b_odd : b_even);
        tot_lines = l0[nf] + 40;
        ph = 0;
        for (int f = 0; f < nf; f++) begin
            int          m;
            int          fp;
            int          bp;
            int          t;
            int          s;
            int          e;
            int          c;
            bit          al;
            logic [15:0] fld;
            m   = 2 * (l0[f] + a_lines) + 1;
            fld = (ph != 0) ? word[31:16] : word[15:0];
            fp  = int'(fld[6:0]);
            al  = fld[7];
            bp  = int'(fld[15:8]);
            t   = m + fp;
            s   = al ? t + 1 : (((t % 2) == 0) ? t + 2 : t + 1);
            e   = s + sync + 1;
            c   = e + bp;
            exp_rise[f] = s;
            exp_fall[f] = e;
            ph = tb_active(c / 2, nf, a_lines) ? 0 : 1 - ph;
        end

        rst          = 1'b1;
        hs_tick      = 1'b0;
        mid_tick     = 1'b0;
        de_in        = dei;
        cfg_timing   = word;
        cfg_sync_len = 8'(sync);
        cfg_de_inv   = dei;
        cfg_vs_inv   = vsi;
        repeat (3) @(posedge clk);
        #1;
        chk(vsync_o === vsi, "R1", {tag, " inactive level in reset"},
            longint'(vsync_o), longint'(vsi));
        rst       = 1'b0;
        tick_idx  = -1;
        last_tick = -1;
        nr        = 0;
        nfl       = 0;
        prev      = 1'b0;
        for (int cyc = 0; cyc < tot_lines * LINE; cyc++) begin
            if (cyc > 0) begin
                @(posedge clk);
                #1;
                vs = vsync_o ^ vsi;
                if (vs && !prev) begin
                    if (nr < MAXF) got_rise[nr] = last_tick;
                    nr++;
                end
                if (!vs && prev) begin
                    if (nfl < MAXF) got_fall[nfl] = last_tick;
                    nfl++;
                end
                prev = vs;
            end
            hs_tick  = ((cyc % LINE) == 0);
            mid_tick = ((cyc % LINE) == HALF);
            if (hs_tick || mid_tick) begin
                tick_idx++;
                last_tick = tick_idx;
            end
            de_in = tb_active(cyc / LINE, nf, a_lines) ^ dei;
        end
        chk(nr == nf, "R2", {tag, " pulse count"}, nr, nf);
        for (int f = 0; f < nf && f < nr && f < nfl; f++) begin
            chk(got_rise[f] == exp_rise[f], req_start,
                $sformatf("%s field %0d start half-line", tag, f),
                got_rise[f], exp_rise[f]);
            chk(got_fall[f] == exp_fall[f], "R5",
                $sformatf("%s field %0d end half-line", tag, f),
                got_fall[f], exp_fall[f]);
        end
    endtask

    // Odd front porch: set 0 starts mid-line, set 1 on a line tick
    task automatic test_odd_porch();
        run_fields(32'h1F061E87, 5, 1'b0, 1'b0, 4, 30, 30, 4,
                   "odd porch", "R2 R3 R4 R6");
    endtask

    // Even front porch: alignment flags swap between the sets
    task automatic test_even_porch();
        run_fields(32'h22872108, 1, 1'b0, 1'b0, 4, 30, 30, 4,
                   "even porch", "R3 R4 R6");
    endtask

    // Set 1 front-porch count of zero
    task automatic test_zero_count();
        run_fields(32'h28002781, 2, 1'b0, 1'b0, 3, 30, 30, 4,
                   "zero count", "R3 R4");
    endtask

    // Back porch ends inside the next field's active lines
    task automatic test_resync();
        run_fields(32'h06810502, 1, 1'b0, 1'b0, 4, 5, 30, 4,
                   "resync", "R7 R6 R4");
    endtask

    // Both polarities inverted
    task automatic test_polarity();
        run_fields(32'h1F061E87, 5, 1'b1, 1'b1, 4, 30, 30, 2,
                   "inverted", "R8 R4");
    endtask

    // Packing function against hand-computed words
    task automatic test_packing();
        logic [31:0] w;
        w = ivs_pkg::pack_timing(16'd480, 16'd489, 16'd495, 16'd525);
        chk(w == 32'h1F061E87, "R9", "pack nominal", w, 32'h1F061E87);
        chk(ivs_pkg::sync_code(16'd489, 16'd495) == 8'd5, "R9", "sync code",
            ivs_pkg::sync_code(16'd489, 16'd495), 5);
        w = ivs_pkg::pack_timing(16'd480, 16'd620, 16'd622, 16'd660);
        chk(w == 32'h34FD337E, "R10", "pack clamp high", w, 32'h34FD337E);
        w = ivs_pkg::pack_timing(16'd480, 16'd481, 16'd483, 16'd485);
        chk(w == 32'h01000081, "R10", "pack clamp low floor", w, 32'h01000081);
        w = ivs_pkg::pack_timing(16'd480, 16'd482, 16'd484, 16'd495);
        chk(w == 32'h0B000A81, "R10", "pack clamp low borrow", w, 32'h0B000A81);
        w = ivs_pkg::pack_timing(16'd481, 16'd489, 16'd495, 16'd524);
        chk(w == 32'h1F061E87, "R11", "pack rounding", w, 32'h1F061E87);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_packing();
        test_odd_porch();
        test_even_porch();
        test_zero_count();
        test_resync();
        test_polarity();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule